// File: doc/BRIEF.md
# SDRAM Low-Power Sequencer

This block sits next to an SDRAM controller's command engine and decides when the attached SDRAM leaves normal operation for a low-power state, and how it gets back. It watches an access-request input. While no request is pending, it counts idle cycles against a programmable threshold. When the threshold is reached, it walks the device into one of three states chosen by a 2-bit mode field: self-refresh, power-down or deep power-down. It drives the clock-enable level and a small command code that the controller's command multiplexer forwards to the device. It also drives a ready signal that stalls the access engine while the device is not usable.

In self-refresh the block keeps the device in that state for a programmable minimum residency. Any request that arrives earlier is held off. On exit it raises clock-enable and waits a programmable exit-to-command delay before granting access. In power-down the block itself wakes the device at a programmable interval for one auto-refresh, then returns it to power-down. Deep power-down is allowed only when the attached part is flagged as a mobile type. Leaving deep power-down raises a one-cycle flag that tells the initialization engine the memory contents are gone.

Top module: `sdram_lp_seq`

## Requirements
- R1: After reset `sd_cke` is 1, `acc_ready` is 1, `sd_cmd` is 0 (no-op) and `reinit_req` is 0.
- R2: The idle threshold L is 0 for `cfg_timeout`=0, 64 for 1, and 128 for 2 or 3. If `acc_req` is low from cycle c0 on, the first cycle of the entry sequence is cycle c0+L+1.
- R3: A cycle with `acc_req` high, while the block is active, restarts the idle count from zero.
- R4: With `cfg_mode`=0, or with `cfg_mode`=3 while `cfg_mobile`=0, the block never leaves the active state: `sd_cke` and `acc_ready` stay 1 and `sd_cmd` stays 0.
- R5: Self-refresh entry (`cfg_mode`=1) issues one cycle of `sd_cmd`=1 (precharge-all) with `sd_cke` high. The next cycle carries `sd_cmd`=3 (self-refresh enter) with `sd_cke` low. Command encoding: 0 no-op, 1 precharge-all, 2 auto-refresh, 3 self-refresh enter, 4 deep power-down enter.
- R6: `sd_cke` stays low in self-refresh for at least max(`cfg_tras`,2) cycles, counting the enter cycle, and for as long as no request arrives. A request held since entry makes `sd_cke` rise exactly after max(`cfg_tras`,2) low cycles. A request arriving after that point makes `sd_cke` rise in the next cycle.
- R7: On self-refresh exit, `sd_cke` is high with `sd_cmd`=0 for max(`cfg_txsr`,1) cycles with `acc_ready` low, after which `acc_ready` rises.
- R8: Power-down entry (`cfg_mode`=2) drives `sd_cke` low directly, with `sd_cmd`=0 and no precharge.
- R9: In power-down without a request, `sd_cke` is low for max(`cfg_refi`,1) cycles. Then comes one cycle with `sd_cke` high and `sd_cmd`=0, one cycle with `sd_cmd`=2 and `sd_cke` high, and then `sd_cke` goes low again.
- R10: A request seen while in power-down raises `sd_cke` in the next cycle, and `acc_ready` rises one cycle after that.
- R11: With `cfg_mode`=3 and `cfg_mobile`=1, entry issues precharge-all and then `sd_cmd`=4 with `sd_cke` low. On a request, one cycle has `sd_cke` high and `reinit_req`=1, and the following cycle has `acc_ready`=1 and `reinit_req`=0.
- R12: `acc_ready` is 0 in every cycle in which `sd_cke` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_mode | input | 2 | Low-power mode: 0 off, 1 self-refresh, 2 power-down, 3 deep power-down |
| cfg_timeout | input | 2 | Idle threshold code: 0, 64 or 128 cycles |
| cfg_mobile | input | 1 | Attached SDRAM is a mobile part (allows deep power-down) |
| cfg_tras | input | TMR_W | Minimum self-refresh residency in cycles |
| cfg_txsr | input | TMR_W | Self-refresh exit-to-command delay in cycles |
| cfg_refi | input | REFI_W | Power-down auto-refresh interval in cycles |
| acc_req | input | 1 | Access request / device selected |
| sd_cke | output | 1 | SDRAM clock-enable level |
| sd_cmd | output | 3 | Command code for the controller's command multiplexer |
| acc_ready | output | 1 | Access engine may issue normal commands |
| reinit_req | output | 1 | One-cycle pulse: contents lost, re-initialization needed |

## Verification
Self-refresh is swept over every residency value from 0 to 5 and every exit delay from 0 to 3. This separates the two clamped lower bounds from the linear range and shows whether the residency count and the exit delay are mixed up. All four timeout codes are run once each, which tells the 0, 64 and 128 thresholds apart and confirms that code 3 aliases to 128. A request blip partway through an idle count shows whether the counter restarts or merely pauses. Power-down is swept over refresh intervals 1 to 5 across two refresh periods, followed by a request. Deep power-down, the disabled mode and the non-mobile deep mode each get a dedicated pattern. Together these separate the entry paths with precharge from the one without, and the exit with the content-loss flag from those without it.

// File: rtl/sdram_lp_pkg.sv
// Package: shared types for the SDRAM low-power sequencer.
// Assumes: command codes are forwarded unchanged by the controller's
// command multiplexer; state encoding is private to the sequencer.
package sdram_lp_pkg;

    // Low-power mode selected by the configuration field.
    typedef enum logic [1:0] {
        LPM_OFF   = 2'd0,
        LPM_SELF  = 2'd1,
        LPM_PDOWN = 2'd2,
        LPM_DEEP  = 2'd3
    } lp_mode_e;

    // Command code handed to the command multiplexer.
    typedef enum logic [2:0] {
        CMD_NOP       = 3'd0,
        CMD_PREALL    = 3'd1,
        CMD_AUTOREF   = 3'd2,
        CMD_SR_ENTER  = 3'd3,
        CMD_DPD_ENTER = 3'd4
    } sd_cmd_e;

    // Sequencer states.
    typedef enum logic [3:0] {
        ST_ACTIVE     = 4'd0,
        ST_PREALL     = 4'd1,
        ST_SR_ENTER   = 4'd2,
        ST_SR_HOLD    = 4'd3,
        ST_SR_EXIT    = 4'd4,
        ST_PD_HOLD    = 4'd5,
        ST_PD_WAKE    = 4'd6,
        ST_PD_REFRESH = 4'd7,
        ST_PD_EXIT    = 4'd8,
        ST_DPD_ENTER  = 4'd9,
        ST_DPD_HOLD   = 4'd10,
        ST_DPD_EXIT   = 4'd11
    } lp_state_e;

endpackage

// File: rtl/lp_idle_timer.sv
// Module: lp_idle_timer
// Counts consecutive idle cycles while the sequencer is active and flags
// when the programmed threshold is reached.
// Assumes: run is high only in the active state; busy is the access request.
module lp_idle_timer #(
    parameter int TO_UNIT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       busy,
    input  logic [1:0] code,
    output logic       hit
);
    localparam int LIM_W = $clog2(2 * TO_UNIT + 1);

    logic [LIM_W-1:0] limit;
    logic [LIM_W-1:0] cnt_q;

    // Decode the 2-bit threshold code into a cycle count.
    always_comb begin
        case (code)
            2'd0:    limit = '0;
            2'd1:    limit = LIM_W'(TO_UNIT);
            default: limit = LIM_W'(2 * TO_UNIT);
        endcase
    end

    // Idle counter: cleared on activity or outside the active state, saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || busy) begin
            cnt_q <= '0;
        end else if (cnt_q < limit) begin
            cnt_q <= cnt_q + LIM_W'(1);
        end
    end

    assign hit = run && !busy && (cnt_q == limit);

    AST_IDLE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $stable(code)) |-> (cnt_q <= limit)) else $error("idle count past limit"); // R2
    AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (cnt_q == '0)) else $error("idle count not restarted"); // R3

endmodule

// File: rtl/lp_wait_counter.sv
// Module: lp_wait_counter
// Loadable down-counter shared by the residency, exit-delay and refresh
// interval waits; reports when it has reached zero.
// Assumes: only one wait is in progress at any time.
module lp_wait_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // Load on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero = (cnt_q == '0);

    AST_WAIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val))) else $error("wait load lost"); // R6

endmodule

// File: rtl/lp_out_decode.sv
// Module: lp_out_decode
// Maps the sequencer state onto the clock-enable level, command code,
// ready handshake and re-initialization flag.
// Assumes: outputs are Moore outputs of the registered state.
module lp_out_decode
    import sdram_lp_pkg::*;
(
    input  lp_state_e state,
    output logic      cke,
    output sd_cmd_e   cmd,
    output logic      ready,
    output logic      reinit
);
    // Per-state output table.
    always_comb begin
        cke    = 1'b1;
        cmd    = CMD_NOP;
        ready  = 1'b0;
        reinit = 1'b0;
        case (state)
            ST_ACTIVE:     ready = 1'b1;
            ST_PREALL:     cmd = CMD_PREALL;
            ST_SR_ENTER: begin
                cke = 1'b0;
                cmd = CMD_SR_ENTER;
            end
            ST_SR_HOLD:    cke = 1'b0;
            ST_PD_HOLD:    cke = 1'b0;
            ST_PD_REFRESH: cmd = CMD_AUTOREF;
            ST_DPD_ENTER: begin
                cke = 1'b0;
                cmd = CMD_DPD_ENTER;
            end
            ST_DPD_HOLD:   cke = 1'b0;
            ST_DPD_EXIT:   reinit = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/sdram_lp_seq.sv
// Module: sdram_lp_seq (top)
// Decides when the SDRAM enters self-refresh, power-down or deep power-down
// after an idle timeout, sequences entry and exit commands, enforces the
// self-refresh residency and exit delay, and schedules auto-refresh wakeups
// in power-down.
// Assumes: configuration inputs are stable while the device is in a
// low-power state; acc_req stays high until acc_ready is seen.
module sdram_lp_seq
    import sdram_lp_pkg::*;
#(
    parameter int TO_UNIT = 64,
    parameter int TMR_W   = 6,
    parameter int REFI_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_timeout,
    input  logic              cfg_mobile,
    input  logic [TMR_W-1:0]  cfg_tras,
    input  logic [TMR_W-1:0]  cfg_txsr,
    input  logic [REFI_W-1:0] cfg_refi,
    input  logic              acc_req,
    output logic              sd_cke,
    output logic [2:0]        sd_cmd,
    output logic              acc_ready,
    output logic              reinit_req
);
    localparam int CNT_W = (REFI_W > TMR_W) ? REFI_W : TMR_W;

    lp_state_e        state_q, state_d;
    lp_mode_e         mode_q, mode_d;
    logic             idle_hit;
    logic             mode_ok;
    logic             wait_load;
    logic [CNT_W-1:0] wait_val;
    logic             wait_zero;
    logic [CNT_W-1:0] tras_m1, txsr_m1, refi_m1;
    logic [CNT_W-1:0] tras_ext, txsr_ext, refi_ext;
    sd_cmd_e          cmd_enum;

    // Idle-threshold detection.
    lp_idle_timer #(.TO_UNIT(TO_UNIT)) u_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_ACTIVE),
        .busy  (acc_req),
        .code  (cfg_timeout),
        .hit   (idle_hit)
    );

    // Shared wait counter.
    lp_wait_counter #(.W(CNT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wait_load),
        .load_val (wait_val),
        .zero     (wait_zero)
    );

    // Output decode.
    lp_out_decode u_out (
        .state  (state_q),
        .cke    (sd_cke),
        .cmd    (cmd_enum),
        .ready  (acc_ready),
        .reinit (reinit_req)
    );
    assign sd_cmd = cmd_enum;

    // Load values are one less than the cycle counts, clamped at zero.
    always_comb begin
        tras_ext = CNT_W'(cfg_tras);
        txsr_ext = CNT_W'(cfg_txsr);
        refi_ext = CNT_W'(cfg_refi);
        tras_m1  = (tras_ext == '0) ? '0 : tras_ext - CNT_W'(1);
        txsr_m1  = (txsr_ext == '0) ? '0 : txsr_ext - CNT_W'(1);
        refi_m1  = (refi_ext == '0) ? '0 : refi_ext - CNT_W'(1);
    end

    // A mode is usable if enabled, and deep power-down only on mobile parts.
    assign mode_ok = (cfg_mode == LPM_SELF) || (cfg_mode == LPM_PDOWN) ||
                     ((cfg_mode == LPM_DEEP) && cfg_mobile);

    // Next-state and wait-counter load selection.
    always_comb begin
        state_d   = state_q;
        mode_d    = mode_q;
        wait_load = 1'b0;
        wait_val  = '0;
        case (state_q)
            ST_ACTIVE: begin
                if (idle_hit && mode_ok) begin
                    mode_d = lp_mode_e'(cfg_mode);
                    if (cfg_mode == LPM_PDOWN) begin
                        state_d   = ST_PD_HOLD;
                        wait_load = 1'b1;
                        wait_val  = refi_m1;
                    end else begin
                        state_d = ST_PREALL;
                    end
                end
            end
            ST_PREALL: begin
                if (mode_q == LPM_DEEP) begin
                    state_d = ST_DPD_ENTER;
                end else begin
                    state_d   = ST_SR_ENTER;
                    wait_load = 1'b1;
                    wait_val  = tras_m1;
                end
            end
            ST_SR_ENTER: state_d = ST_SR_HOLD;
            ST_SR_HOLD: begin
                if (acc_req && wait_zero) begin
                    state_d   = ST_SR_EXIT;
                    wait_load = 1'b1;
                    wait_val  = txsr_m1;
                end
            end
            ST_SR_EXIT: begin
                if (wait_zero) state_d = ST_ACTIVE;
            end
            ST_PD_HOLD: begin
                if (acc_req)        state_d = ST_PD_EXIT;
                else if (wait_zero) state_d = ST_PD_WAKE;
            end
            ST_PD_WAKE: state_d = ST_PD_REFRESH;
            ST_PD_REFRESH: begin
                if (acc_req) begin
                    state_d = ST_ACTIVE;
                end else begin
                    state_d   = ST_PD_HOLD;
                    wait_load = 1'b1;
                    wait_val  = refi_m1;
                end
            end
            ST_PD_EXIT:   state_d = ST_ACTIVE;
            ST_DPD_ENTER: state_d = ST_DPD_HOLD;
            ST_DPD_HOLD: begin
                if (acc_req) state_d = ST_DPD_EXIT;
            end
            ST_DPD_EXIT:  state_d = ST_ACTIVE;
            default:      state_d = ST_ACTIVE;
        endcase
    end

    // State and latched-mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
            mode_q  <= LPM_OFF;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
        end
    end

    // Checker-only count of consecutive clock-enable-low cycles.
    logic [TMR_W:0] chk_low_q;
    always_ff @(posedge clk) begin
        if (!rst_n || sd_cke) begin
            chk_low_q <= '0;
        end else if (chk_low_q != '1) begin
            chk_low_q <= chk_low_q + (TMR_W+1)'(1);
        end
    end

    AST_LOW_CKE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_cke |-> !acc_ready) else $error("ready while cke low"); // R12
    AST_SR_ENTER_AFTER_PREALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_SR_ENTER) |-> ($past(sd_cmd) == CMD_PREALL) && !sd_cke) else $error("bad self-refresh entry"); // R5
    AST_SR_RESIDENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SR_EXIT && $past(state_q) == ST_SR_HOLD) |-> (chk_low_q >= {1'b0, cfg_tras})) else $error("residency too short"); // R6
    AST_READY_AFTER_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_ready) |-> $past(sd_cke)) else $error("ready without cke"); // R7
    AST_REFRESH_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_AUTOREF) |-> ($past(state_q) == ST_PD_WAKE) && sd_cke) else $error("refresh without wake"); // R9
    AST_REINIT_FROM_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_req |-> ($past(state_q) == ST_DPD_HOLD)) else $error("reinit outside deep exit"); // R11
    AST_OFF_STAYS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && cfg_mode == LPM_OFF) |=> (state_q == ST_ACTIVE)) else $error("left active while off"); // R4
    AST_DEEP_NEEDS_MOBILE: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_DPD_ENTER) |-> $past(cfg_mobile, 2)) else $error("deep entry on non-mobile"); // R11

endmodule

// File: tb/sdram_lp_seq_tb.sv
module sdram_lp_seq_tb;
    localparam int TMR_W  = 6;
    localparam int REFI_W = 10;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [1:0]        cfg_mode;
    logic [1:0]        cfg_timeout;
    logic              cfg_mobile;
    logic [TMR_W-1:0]  cfg_tras;
    logic [TMR_W-1:0]  cfg_txsr;
    logic [REFI_W-1:0] cfg_refi;
    logic              acc_req;
    logic              sd_cke;
    logic [2:0]        sd_cmd;
    logic              acc_ready;
    logic              reinit_req;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;  // 250 MHz

    sdram_lp_seq #(.TO_UNIT(64), .TMR_W(TMR_W), .REFI_W(REFI_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_timeout(cfg_timeout),
        .cfg_mobile(cfg_mobile), .cfg_tras(cfg_tras), .cfg_txsr(cfg_txsr),
        .cfg_refi(cfg_refi), .acc_req(acc_req), .sd_cke(sd_cke), .sd_cmd(sd_cmd),
        .acc_ready(acc_ready), .reinit_req(reinit_req)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_eq(input string rq, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int thresh(input int code);
        return (code == 0) ? 0 : (code == 1) ? 64 : 128;
    endfunction

    task automatic go_active();
        acc_req = 1'b1;
        for (int i = 0; i < 300 && !acc_ready; i++) tick();
        tick();
    endtask

    // Count cycles from idle start until the first non-idle output.
    task automatic wait_entry(output int n);
        n = 0;
        while (n < 400 && sd_cmd == 3'd0 && sd_cke) begin
            tick();
            n++;
        end
    endtask

    task automatic sr_run(input int code, input int tras, input int txsr);
        int n, low, hi, badrdy;
        cfg_mode = 2'd1; cfg_timeout = 2'(code); cfg_mobile = 1'b0;
        cfg_tras = TMR_W'(tras); cfg_txsr = TMR_W'(txsr);
        go_active();
        acc_req = 1'b0;
        wait_entry(n);
        check_eq("R2", "cycles to entry", n, thresh(code) + 1);
        check_eq("R5", "precharge cmd", sd_cmd, 1);
        check_eq("R5", "cke during precharge", sd_cke, 1);
        tick();
        check_eq("R5", "self-refresh enter cmd", sd_cmd, 3);
        check_eq("R5", "cke at enter", sd_cke, 0);
        acc_req = 1'b1;
        low = 1; badrdy = 0;
        while (low < 100) begin
            if (acc_ready) badrdy++;
            tick();
            if (sd_cke) break;
            low++;
        end
        check_eq("R12", "ready while cke low", badrdy, 0);
        check_eq("R6", "self-refresh low cycles", low, max2(tras, 2));
        hi = 0;
        while (!acc_ready && hi < 100) begin
            if (!sd_cke || sd_cmd != 3'd0) check_eq("R7", "cke/cmd in exit", {sd_cke, sd_cmd}, 8);
            hi++;
            tick();
        end
        check_eq("R7", "exit delay cycles", hi, max2(txsr, 1));
    endtask

    task automatic pd_run(input int refi);
        int low;
        cfg_mode = 2'd2; cfg_timeout = 2'd0; cfg_refi = REFI_W'(refi);
        go_active();
        acc_req = 1'b0;
        tick();
        check_eq("R8", "cke at power-down entry", sd_cke, 0);
        check_eq("R8", "cmd at power-down entry", sd_cmd, 0);
        for (int p = 0; p < 2; p++) begin
            low = 1;
            while (low < 100) begin
                tick();
                if (sd_cke) break;
                low++;
            end
            check_eq("R9", "power-down low cycles", low, max2(refi, 1));
            check_eq("R9", "wake cmd", sd_cmd, 0);
            tick();
            check_eq("R9", "auto-refresh cmd", sd_cmd, 2);
            check_eq("R9", "cke at refresh", sd_cke, 1);
            tick();
            check_eq("R9", "cke back low", sd_cke, 0);
        end
        acc_req = 1'b1;
        tick();
        check_eq("R10", "cke after request", sd_cke, 1);
        check_eq("R10", "ready one cycle after cke", acc_ready, 0);
        tick();
        check_eq("R10", "ready", acc_ready, 1);
    endtask

    task automatic stay_active(input int mode, input int mobile, input string rq);
        int bad;
        cfg_mode = 2'(mode); cfg_mobile = mobile[0]; cfg_timeout = 2'd0;
        go_active();
        acc_req = 1'b0;
        bad = 0;
        for (int i = 0; i < 150; i++) begin
            tick();
            if (!sd_cke || !acc_ready || sd_cmd != 3'd0) bad++;
        end
        check_eq(rq, "cycles outside active", bad, 0);
    endtask

    initial begin
        int n;
        rst_n = 1'b0; acc_req = 1'b1; cfg_mode = 2'd0; cfg_timeout = 2'd0;
        cfg_mobile = 1'b0; cfg_tras = '0; cfg_txsr = '0; cfg_refi = 10'd1;
        repeat (3) tick();
        rst_n = 1'b1;
        check_eq("R1", "cke after reset", sd_cke, 1);
        check_eq("R1", "ready after reset", acc_ready, 1);
        check_eq("R1", "cmd after reset", sd_cmd, 0);
        check_eq("R1", "reinit after reset", reinit_req, 0);

        // R6 R7 sweep of residency and exit delay
        for (int t = 0; t < 6; t++)
            for (int x = 0; x < 4; x++) sr_run(0, t, x);
        // R2 all threshold codes
        for (int c = 1; c < 4; c++) sr_run(c, 3, 2);

        // R6 late request: cke rises the next cycle
        cfg_mode = 2'd1; cfg_timeout = 2'd0; cfg_tras = 6'd4; cfg_txsr = 6'd1;
        go_active();
        acc_req = 1'b0;
        tick(); tick();
        check_eq("R5", "enter cmd late case", sd_cmd, 3);
        for (int i = 0; i < 10; i++) tick();
        check_eq("R6", "cke held low while idle", sd_cke, 0);
        acc_req = 1'b1;
        tick();
        check_eq("R6", "cke rises after late request", sd_cke, 1);

        // R3 restart of the idle count
        cfg_mode = 2'd1; cfg_timeout = 2'd1; cfg_tras = 6'd2;
        go_active();
        acc_req = 1'b0;
        for (int i = 0; i < 40; i++) tick();
        check_eq("R3", "still active mid-count", acc_ready, 1);
        acc_req = 1'b1;
        tick();
        acc_req = 1'b0;
        wait_entry(n);
        check_eq("R3", "cycles to entry after restart", n, 65);

        // R9 R10 power-down refresh sweep
        for (int r = 1; r < 6; r++) pd_run(r);

        // R11 deep power-down
        cfg_mode = 2'd3; cfg_mobile = 1'b1; cfg_timeout = 2'd0;
        go_active();
        acc_req = 1'b0;
        tick();
        check_eq("R11", "precharge before deep", sd_cmd, 1);
        tick();
        check_eq("R11", "deep enter cmd", sd_cmd, 4);
        check_eq("R11", "cke at deep enter", sd_cke, 0);
        repeat (5) tick();
        check_eq("R11", "cke held low", sd_cke, 0);
        acc_req = 1'b1;
        tick();
        check_eq("R11", "cke at deep exit", sd_cke, 1);
        check_eq("R11", "reinit flag", reinit_req, 1);
        check_eq("R11", "ready during exit", acc_ready, 0);
        tick();
        check_eq("R11", "ready after exit", acc_ready, 1);
        check_eq("R11", "reinit pulse ends", reinit_req, 0);

        // R4 disabled and non-mobile deep mode
        stay_active(0, 1, "R4");
        stay_active(3, 0, "R4");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule